// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM audio from a three-wire serial link (a bit clock, a left/right frame clock and a data line) and presents each completed stereo pair as two parallel 18-bit samples with a one-cycle valid strobe in the system clock domain. A format input selects one of four framings: left-justified, I2S, right-justified or DSP-style frame pulse. A word-length input selects 16-bit or 18-bit samples. Data on the line is MSB first and two's complement.

The bit clock serves only as a data strobe. The receiver samples the frame clock and the data line on each rising bit-clock edge and detects word boundaries from changes in the frame clock. Because of this, it needs no fixed number of bit clocks per frame. Completed pairs are held in the bit-clock domain and passed to the system clock through a toggle handshake.

The format and word-length inputs are meant to be set while reset is asserted and held stable afterwards. On the first rising bit-clock edge after reset, the receiver only records the frame-clock level and detects no boundary.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is asserted and after its release, leftOut and rightOut read zero and pairValid is low until the first pair completes.
- R2: With fmtSel = 0 (left-justified), the MSB is the bit sampled on the first rising bit-clock edge at which the frame clock shows its new level. A high frame clock marks the left channel.
- R3: With fmtSel = 1 (I2S), the MSB is sampled one bit clock after the first edge showing the new frame-clock level. A low frame clock marks the left channel.
- R4: With fmtSel = 2 (right-justified), a frame-clock change closes a word. The word is the last N bits sampled before the change, with the LSB being the bit immediately before it. The channel is the level before the change, and high means left. Earlier bits in the half-frame are ignored.
- R5: With fmtSel = 3 (DSP), a frame clock that is high for one bit clock marks a frame. The left MSB follows on the next bit, and the right MSB follows directly after the left LSB.
- R6: wordLong = 1 selects N = 18 and wordLong = 0 selects N = 16. In left-justified, I2S and DSP formats, bits after a word's LSB have no effect on the output.
- R7: 16-bit words are sign-extended from bit 15 to the 18-bit outputs. 18-bit words are passed through unchanged.
- R8: Each completed right word gives exactly one pairValid pulse of one system-clock cycle. The pulse carries that right word and the left word received before it, and both outputs stay unchanged between pulses.
- R9: Half-frames of any length of at least one word (plus the leading bit for I2S and the pulse bit for DSP) are received correctly. Length may vary from frame to frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | System clock for the parallel outputs |
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| bitClk | input | 1 | Serial bit clock; data and frame clock are sampled on its rising edge |
| lrClk | input | 1 | Left/right frame clock or frame pulse |
| serData | input | 1 | Serial audio data, MSB first |
| fmtSel | input | 2 | Framing: 0 left-justified, 1 I2S, 2 right-justified, 3 DSP |
| wordLong | input | 1 | 1 for 18-bit words, 0 for 16-bit words |
| leftOut | output | 18 | Left sample, sign-extended |
| rightOut | output | 18 | Right sample, sign-extended |
| pairValid | output | 1 | One-cycle strobe marking a new stereo pair |

## Verification
A pair completes on the rising bit-clock edge that samples the right LSB, or on the frame-clock change in right-justified mode. The valid strobe and the new samples then appear on the third system-clock edge after that bit-clock edge, once the toggle has passed two synchronizer flops and the edge detector. Since this delay is short but depends on clock phase, the monitor does not sample at a fixed cycle. It compares each strobe against a queue of expected pairs that the driver fills in sending order. After every format group, the bench allows a wait far longer than four system cycles. At the end, an expected pair that never arrived counts as a failure, and so does a strobe longer than one cycle.

// File: rtl/asr_pkg.sv
package asr_pkg;

  typedef enum logic [1:0] {
    FMT_LEFT  = 2'd0,
    FMT_I2S   = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_DSP   = 2'd3
  } fmt_e;

  // strobes from framing control to the datapath, bit-clock domain
  typedef struct packed {
    logic takeLive;  // word ends with the bit sampled now
    logic takeHeld;  // word ended with the previous bit (right-justified)
    logic toLeft;    // the finished word belongs to the left channel
  } capStrobe_t;

endpackage

// File: rtl/asr_ctrl.sv
module asr_ctrl
  import asr_pkg::*;
#(
  parameter int unsigned LONG_W  = 18,
  parameter int unsigned SHORT_W = 16
) (
  input  logic       bitClk,
  input  logic       rstN,
  input  logic       lrClk,
  input  fmt_e       fmt,
  input  logic       wordLong,
  output capStrobe_t strobe
);
  localparam int unsigned CW = $clog2(LONG_W + 1);

  logic          lrPrev, lrPrev2;
  logic [1:0]    histOk;
  logic [CW-1:0] bitCnt;
  logic          active, chanLeft;

  logic [CW-1:0] wordLen;
  logic          edgeNow, edgeLast, pulseLast;
  logic          start, startLeft, heldCap, running, liveCap, curLeft;
  logic [CW-1:0] cntNext;

  assign wordLen   = wordLong ? CW'(LONG_W) : CW'(SHORT_W);
  assign edgeNow   = histOk[0] & (lrClk ^ lrPrev);
  assign edgeLast  = histOk[1] & (lrPrev ^ lrPrev2);
  assign pulseLast = histOk[1] & lrPrev & ~lrPrev2;

  always_comb begin
    start     = 1'b0;
    startLeft = 1'b0;
    heldCap   = 1'b0;
    unique case (fmt)
      FMT_LEFT:  begin start = edgeNow;   startLeft = lrClk;   end
      FMT_I2S:   begin start = edgeLast;  startLeft = ~lrPrev; end
      FMT_DSP:   begin start = pulseLast; startLeft = 1'b1;    end
      FMT_RIGHT: heldCap = edgeNow;
      default:   heldCap = 1'b0;
    endcase
  end

  assign cntNext = start ? CW'(1) : bitCnt + CW'(1);
  assign running = start | active;
  assign liveCap = running & (cntNext == wordLen);
  assign curLeft = start ? startLeft : chanLeft;

  assign strobe.takeLive = liveCap;
  assign strobe.takeHeld = heldCap;
  assign strobe.toLeft   = heldCap ? lrPrev : curLeft;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      lrPrev   <= 1'b0;
      lrPrev2  <= 1'b0;
      histOk   <= '0;
      bitCnt   <= '0;
      active   <= 1'b0;
      chanLeft <= 1'b0;
    end else begin
      lrPrev  <= lrClk;
      lrPrev2 <= lrPrev;
      histOk  <= {histOk[0], 1'b1};
      if (liveCap && curLeft && fmt == FMT_DSP) begin
        active   <= 1'b1;   // right word follows with no gap
        bitCnt   <= '0;
        chanLeft <= 1'b0;
      end else if (liveCap) begin
        active <= 1'b0;
      end else if (running) begin
        active   <= 1'b1;
        bitCnt   <= cntNext;
        chanLeft <= curLeft;
      end
    end
  end

  // R6: a word in progress never counts past its selected length
  a_r6_cnt_bound: assert property (@(posedge bitClk) disable iff (!rstN)
    active |-> (bitCnt < wordLen));

  // R4: a held-word capture only happens on a frame-clock change
  a_r4_held_on_edge: assert property (@(posedge bitClk) disable iff (!rstN)
    strobe.takeHeld |-> (lrClk != $past(lrClk)));

  // R5: the left word's end in DSP mode opens the right word at once
  a_r5_dsp_chain: assert property (@(posedge bitClk) disable iff (!rstN)
    (fmt == FMT_DSP && strobe.takeLive && strobe.toLeft)
      |=> (active && !chanLeft && bitCnt == '0));

endmodule

// File: rtl/asr_dpath.sv
module asr_dpath
  import asr_pkg::*;
#(
  parameter int unsigned LONG_W  = 18,
  parameter int unsigned SHORT_W = 16
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              serData,
  input  logic              wordLong,
  input  capStrobe_t        strobe,
  output logic [LONG_W-1:0] pairLeft,
  output logic [LONG_W-1:0] pairRight,
  output logic              pairTgl
);
  localparam int unsigned EXT_W = LONG_W - SHORT_W;

  logic [LONG_W-1:0] shiftReg, nextShift, rawWord, sample, leftWork;
  logic              take;

  assign nextShift = {shiftReg[LONG_W-2:0], serData};
  assign rawWord   = strobe.takeHeld ? shiftReg : nextShift;
  assign sample    = wordLong ? rawWord
                              : {{EXT_W{rawWord[SHORT_W-1]}}, rawWord[SHORT_W-1:0]};
  assign take      = strobe.takeLive | strobe.takeHeld;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      leftWork  <= '0;
      pairLeft  <= '0;
      pairRight <= '0;
      pairTgl   <= 1'b0;
    end else begin
      shiftReg <= nextShift;
      if (take) begin
        if (strobe.toLeft) begin
          leftWork <= sample;
        end else begin
          pairLeft  <= leftWork;
          pairRight <= sample;
          pairTgl   <= ~pairTgl;
        end
      end
    end
  end

  // R7: in short-word mode the held pair carries copies of bit 15 above it
  a_r7_short_sext: assert property (@(posedge bitClk) disable iff (!rstN)
    !wordLong |-> (pairRight[LONG_W-1:SHORT_W] == {EXT_W{pairRight[SHORT_W-1]}}
                && pairLeft[LONG_W-1:SHORT_W]  == {EXT_W{pairLeft[SHORT_W-1]}}));

endmodule

// File: rtl/asr_xfer.sv
module asr_xfer #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  logic              pairTgl,
  input  logic [DATA_W-1:0] pairLeft,
  input  logic [DATA_W-1:0] pairRight,
  output logic [DATA_W-1:0] leftOut,
  output logic [DATA_W-1:0] rightOut,
  output logic              pairValid
);
  logic [SYNC_N:0] syncQ;
  logic            seen;

  assign seen = syncQ[SYNC_N] ^ syncQ[SYNC_N-1];

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      pairValid <= 1'b0;
      leftOut   <= '0;
      rightOut  <= '0;
    end else begin
      syncQ     <= {syncQ[SYNC_N-1:0], pairTgl};
      pairValid <= seen;
      if (seen) begin
        leftOut  <= pairLeft;
        rightOut <= pairRight;
      end
    end
  end

  // R8: the strobe lasts a single system cycle
  a_r8_one_cycle: assert property (@(posedge sysClk) disable iff (!rstN)
    pairValid |=> !pairValid);

  // R8: samples change only together with the strobe
  a_r8_hold: assert property (@(posedge sysClk) disable iff (!rstN)
    (leftOut != $past(leftOut) || rightOut != $past(rightOut)) |-> pairValid);

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import asr_pkg::*;
#(
  parameter int unsigned LONG_W  = 18,
  parameter int unsigned SHORT_W = 16,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              lrClk,
  input  logic              serData,
  input  logic [1:0]        fmtSel,
  input  logic              wordLong,
  output logic [LONG_W-1:0] leftOut,
  output logic [LONG_W-1:0] rightOut,
  output logic              pairValid
);
  capStrobe_t        strobe;
  logic [LONG_W-1:0] pairLeft, pairRight;
  logic              pairTgl;
  fmt_e              fmt;

  assign fmt = fmt_e'(fmtSel);

  asr_ctrl #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) ctrl_i (
    .bitClk(bitClk), .rstN(rstN), .lrClk(lrClk), .fmt(fmt),
    .wordLong(wordLong), .strobe(strobe)
  );

  asr_dpath #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) dpath_i (
    .bitClk(bitClk), .rstN(rstN), .serData(serData), .wordLong(wordLong),
    .strobe(strobe), .pairLeft(pairLeft), .pairRight(pairRight), .pairTgl(pairTgl)
  );

  asr_xfer #(.DATA_W(LONG_W), .SYNC_N(SYNC_N)) xfer_i (
    .sysClk(sysClk), .rstN(rstN), .pairTgl(pairTgl), .pairLeft(pairLeft),
    .pairRight(pairRight), .leftOut(leftOut), .rightOut(rightOut),
    .pairValid(pairValid)
  );

endmodule

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb_top;
  logic        sysClk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitClk = 1'b0;
  logic        lrClk = 1'b0;
  logic        serData = 1'b0;
  logic [1:0]  fmtSel = 2'd0;
  logic        wordLong = 1'b0;
  logic [17:0] leftOut, rightOut;
  logic        pairValid;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  logic [35:0] expQ[$];
  string       tagQ[$];

  always #4 sysClk = ~sysClk;  // 125 MHz

  pcm_serial_rx dut_i (
    .sysClk(sysClk), .rstN(rstN), .bitClk(bitClk), .lrClk(lrClk),
    .serData(serData), .fmtSel(fmtSel), .wordLong(wordLong),
    .leftOut(leftOut), .rightOut(rightOut), .pairValid(pairValid)
  );

  function automatic logic [17:0] extend(input logic [17:0] v, input logic lng);
    return lng ? v : {{2{v[15]}}, v[15:0]};
  endfunction

  task automatic bitOut(input logic lr, input logic d);
    lrClk = lr; serData = d;
    #40 bitClk = 1'b1;
    #40 bitClk = 1'b0;
  endtask

  task automatic startGroup(input logic [1:0] f, input logic lng);
    rstN = 1'b0; fmtSel = f; wordLong = lng; bitClk = 1'b0; serData = 1'b0;
    #200 rstN = 1'b1;
    #200;
    for (int i = 0; i < 2; i++) bitOut((f == 2'd1 || f == 2'd2), 1'b0);
  endtask

  task automatic endGroup(input logic [1:0] f);
    if (f == 2'd2) bitOut(1'b1, 1'b0);  // closing edge for the last right word
    #2000;
  endtask

  // pad bits are driven high to show they are ignored (R6)
  task automatic sendPair(input logic [1:0] f, input logic [17:0] l, input logic [17:0] r,
                          input int slot, input string tag);
    int n = wordLong ? 18 : 16;
    expQ.push_back({extend(l, wordLong), extend(r, wordLong)});
    tagQ.push_back(tag);
    case (f)
      2'd0: begin
        for (int i = 0; i < slot; i++) bitOut(1'b1, i < n ? l[n-1-i] : 1'b1);
        for (int i = 0; i < slot; i++) bitOut(1'b0, i < n ? r[n-1-i] : 1'b1);
      end
      2'd1: begin
        for (int i = 0; i < slot; i++) bitOut(1'b0, (i >= 1 && i <= n) ? l[n-i] : 1'b1);
        for (int i = 0; i < slot; i++) bitOut(1'b1, (i >= 1 && i <= n) ? r[n-i] : 1'b1);
      end
      2'd2: begin
        for (int i = 0; i < slot; i++) bitOut(1'b1, i >= slot-n ? l[slot-1-i] : 1'b1);
        for (int i = 0; i < slot; i++) bitOut(1'b0, i >= slot-n ? r[slot-1-i] : 1'b1);
      end
      default: begin
        bitOut(1'b1, 1'b1);
        for (int i = 0; i < n; i++) bitOut(1'b0, l[n-1-i]);
        for (int i = 0; i < n; i++) bitOut(1'b0, r[n-1-i]);
        for (int i = 0; i < slot - 2*n - 1; i++) bitOut(1'b0, 1'b1);
      end
    endcase
  endtask

  task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops one expected pair per strobe
  logic [35:0] lastPair = '0;
  bit          prevValid = 0;
  bit          holdBroken = 0;
  bit          longStrobe = 0;
  always @(negedge sysClk) begin
    if (!rstN) begin
      lastPair  <= '0;
      prevValid <= 0;
    end else begin
      if (pairValid && prevValid) longStrobe <= 1;
      if (pairValid && !prevValid) begin
        if (expQ.size() == 0) begin
          nRun++; nFail++;
          $display("FAIL R8: unexpected strobe got %h expected none", {leftOut, rightOut});
        end else begin
          check(tagQ.pop_front(), {leftOut, rightOut}, expQ.pop_front());
        end
        lastPair <= {leftOut, rightOut};
      end else if (!pairValid && {leftOut, rightOut} !== lastPair) begin
        holdBroken <= 1;
      end
      prevValid <= pairValid;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    #150;
    check("R1 reset held", {leftOut, rightOut, 1'b0}, {36'd0, pairValid} & 37'd0 | {36'd0, pairValid});
    check("R1 valid low in reset", {35'd0, pairValid}, 36'd0);
    #100 rstN = 1'b1;
    #200;
    check("R1 after release", {leftOut, rightOut}, 36'd0);

    startGroup(2'd0, 1'b1);
    sendPair(2'd0, 18'h1ABCD, 18'h00001, 18, "R2");
    sendPair(2'd0, 18'h20000, 18'h1FFFF, 25, "R9");
    endGroup(2'd0);

    startGroup(2'd0, 1'b0);
    sendPair(2'd0, 18'h08000, 18'h07FFF, 16, "R7");
    sendPair(2'd0, 18'h0FFFF, 18'h01234, 32, "R6");
    endGroup(2'd0);

    startGroup(2'd1, 1'b0);
    sendPair(2'd1, 18'h0A5A5, 18'h05A5A, 17, "R3");
    sendPair(2'd1, 18'h00001, 18'h0FFFE, 32, "R3");
    endGroup(2'd1);

    startGroup(2'd1, 1'b1);
    sendPair(2'd1, 18'h2AAAA, 18'h15555, 19, "R3");
    sendPair(2'd1, 18'h3FFFE, 18'h00003, 24, "R9");
    endGroup(2'd1);

    startGroup(2'd2, 1'b0);
    sendPair(2'd2, 18'h0C001, 18'h03FFE, 16, "R4");
    sendPair(2'd2, 18'h08001, 18'h00100, 24, "R4");
    endGroup(2'd2);

    startGroup(2'd2, 1'b1);
    sendPair(2'd2, 18'h12345, 18'h2FEDC, 20, "R4");
    endGroup(2'd2);

    startGroup(2'd3, 1'b0);
    sendPair(2'd3, 18'h0BEEF, 18'h00F0F, 33, "R5");
    sendPair(2'd3, 18'h04000, 18'h0C000, 40, "R5");
    endGroup(2'd3);

    startGroup(2'd3, 1'b1);
    sendPair(2'd3, 18'h3C3C3, 18'h00FF0, 37, "R5");
    endGroup(2'd3);

    check("R8 all pairs delivered", {4'd0, 32'(expQ.size())}, 36'd0);
    check("R8 single-cycle strobe", {35'd0, longStrobe}, 36'd0);
    check("R8 outputs held between strobes", {35'd0, holdBroken}, 36'd0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 120000);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule